// File: doc/BRIEF.md
# Software Interrupt Signal Register

The block keeps four event flags on an 8-bit I/O bus: two location-monitor flags and two software-signal flags, one of each per interrupt line. Software never writes a flag directly. It writes one-shot set and clear strobes into a control register that reads back as zero. A second, remote write port reaches the same control register, so a master on another bus can raise an interrupt to the local processor.

The upper half of the status register holds one enable per flag. Each of the two interrupt outputs is a registered, active-high level. It is driven by the line's software-signal flag or its location-monitor flag, each gated by its own enable. The level stays high until the flag is cleared or its enable is dropped.

Top module: `sig_irq_regs`

## Requirements
- R1: After reset, all eight status bits read 0 and both interrupt outputs are 0.
- R2: A local write to the status address (default 0x1001) loads bits 7..4 as enables, in the order signal-1, signal-0, monitor-1, monitor-0 from bit 7 down. A read of the status address returns {enables, sig1, sig0, lm1, lm0}, with the flags in bits 3..0.
- R3: Bits 3..0 of a write to the status address do not change any flag.
- R4: A write to the control address (default 0x1000) with bit 7, 6, 5 or 4 at 1 sets flag sig1, sig0, lm1 or lm0 respectively.
- R5: Control bits 3, 2, 1, 0 at 1 clear sig1, sig0, lm1, lm0. A control bit at 0 leaves its flag unchanged.
- R6: If a set strobe and a clear strobe for the same flag arrive in one cycle, the flag ends up set.
- R7: The remote port writes the control register alone. When both ports write the control register in the same cycle, their strobes are ORed.
- R8: irq_o[n] equals (sig_n AND en_sig_n) OR (lm_n AND en_lm_n), taken from the status as it stood one clock earlier.
- R9: Reads of the control address, and of any address other than the status address, return 0.
- R10: A local write to an address that is neither the status address nor the control address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W (16) | Local I/O address |
| bus_wr_i | input | 1 | Local write strobe |
| bus_wdata_i | input | 8 | Local write data |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| rmt_wr_i | input | 1 | Remote control-register write strobe |
| rmt_wdata_i | input | 8 | Remote control write data |
| irq_o | output | 2 | Level interrupt lines, bit n is line n |

## Verification
Random cycles mix local writes to the status address, the control address and unrelated addresses with remote control writes, and each port sometimes writes alone. The random mix tells apart errors in the OR of the two ports, in the per-flag set/clear priority and in the enable gating of each line. Directed sequences then isolate several cases. One is a set and a clear for the same flag in a single write. Another is both ports writing in one cycle. The others are a zero control write, a write to an unrelated address, and the one-cycle delay of the interrupt after a flag or an enable changes.

// File: rtl/sig_irq_pkg.sv
package sig_irq_pkg;
  // field index; field f of a register spans [f*LINES +: LINES]
  localparam int unsigned FLD_LM      = 0;
  localparam int unsigned FLD_SIG     = 1;
  localparam int unsigned FLD_EN_LM   = 2;
  localparam int unsigned FLD_EN_SIG  = 3;
  localparam int unsigned FLD_CLR_LM  = 0;
  localparam int unsigned FLD_CLR_SIG = 1;
  localparam int unsigned FLD_SET_LM  = 2;
  localparam int unsigned FLD_SET_SIG = 3;
  localparam int unsigned NUM_FLD     = 4;
endpackage

// File: rtl/sig_irq_decode.sv
module sig_irq_decode
  import sig_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned LINES       = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h1001,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h1000,
  localparam int unsigned DW = NUM_FLD * LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic              rmt_wr_i,
  input  logic [DW-1:0]     rmt_wdata_i,
  input  logic [DW-1:0]     status_i,
  output logic              en_we_o,
  output logic [2*LINES-1:0] en_wdata_o,
  output logic [LINES-1:0]  set_sig_o,
  output logic [LINES-1:0]  set_lm_o,
  output logic [LINES-1:0]  clr_sig_o,
  output logic [LINES-1:0]  clr_lm_o,
  output logic [DW-1:0]     rdata_o
);
  logic          hit_st, hit_ct;
  logic [DW-1:0] loc_strb, rmt_strb, strb;

  assign hit_st = (bus_addr_i == STATUS_ADDR);
  assign hit_ct = (bus_addr_i == CTRL_ADDR);

  assign loc_strb = (bus_wr_i && hit_ct) ? bus_wdata_i : '0;
  assign rmt_strb = rmt_wr_i ? rmt_wdata_i : '0;
  assign strb     = loc_strb | rmt_strb;

  assign set_sig_o = strb[FLD_SET_SIG*LINES +: LINES];
  assign set_lm_o  = strb[FLD_SET_LM*LINES  +: LINES];
  assign clr_sig_o = strb[FLD_CLR_SIG*LINES +: LINES];
  assign clr_lm_o  = strb[FLD_CLR_LM*LINES  +: LINES];

  assign en_we_o    = bus_wr_i && hit_st;
  assign en_wdata_o = bus_wdata_i[DW-1 -: 2*LINES];

  // control register is write-only strobes: reads 0
  assign rdata_o = hit_st ? status_i : '0;

  // R10
  stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !hit_st && !hit_ct && !rmt_wr_i) |->
      (!en_we_o && set_sig_o == '0 && set_lm_o == '0 && clr_sig_o == '0 && clr_lm_o == '0));
  // R9
  ctrl_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_st |-> rdata_o == '0);
endmodule

// File: rtl/sig_irq_flag_bank.sv
module sig_irq_flag_bank #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;  // set dominates
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_o[i]);
    // R5
    clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(flag_o[i]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sig_irq_out.sv
module sig_irq_out #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] sig_i,
  input  logic [LINES-1:0] lm_i,
  input  logic [LINES-1:0] en_sig_i,
  input  logic [LINES-1:0] en_lm_i,
  output logic [LINES-1:0] irq_o
);
  logic [LINES-1:0] hit, irq_q;

  assign hit = (sig_i & en_sig_i) | (lm_i & en_lm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit;
  end

  assign irq_o = irq_q;

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R8
    irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sig_i[i] && !lm_i[i]) |=> !irq_o[i]);
    // R8
    irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_sig_i[i] && !en_lm_i[i]) |=> !irq_o[i]);
  end
endmodule

// File: rtl/sig_irq_regs.sv
module sig_irq_regs
  import sig_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned LINES       = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h1001,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h1000,
  localparam int unsigned DW = NUM_FLD * LINES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              rmt_wr_i,
  input  logic [DW-1:0]     rmt_wdata_i,
  output logic [LINES-1:0]  irq_o
);
  logic               en_we;
  logic [2*LINES-1:0] en_wdata, en_q;
  logic [LINES-1:0]   set_sig, set_lm, clr_sig, clr_lm, sig_q, lm_q;
  logic [DW-1:0]      status;

  assign status = {en_q, sig_q, lm_q};

  sig_irq_decode #(
    .ADDR_W(ADDR_W), .LINES(LINES),
    .STATUS_ADDR(STATUS_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .clk_i, .rst_ni,
    .bus_addr_i, .bus_wr_i, .bus_wdata_i,
    .rmt_wr_i, .rmt_wdata_i,
    .status_i   (status),
    .en_we_o    (en_we),
    .en_wdata_o (en_wdata),
    .set_sig_o  (set_sig),
    .set_lm_o   (set_lm),
    .clr_sig_o  (clr_sig),
    .clr_lm_o   (clr_lm),
    .rdata_o    (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  sig_irq_flag_bank #(.W(LINES)) u_sig (
    .clk_i, .rst_ni, .set_i(set_sig), .clr_i(clr_sig), .flag_o(sig_q)
  );

  sig_irq_flag_bank #(.W(LINES)) u_lm (
    .clk_i, .rst_ni, .set_i(set_lm), .clr_i(clr_lm), .flag_o(lm_q)
  );

  sig_irq_out #(.LINES(LINES)) u_out (
    .clk_i, .rst_ni,
    .sig_i    (sig_q),
    .lm_i     (lm_q),
    .en_sig_i (en_q[2*LINES-1 -: LINES]),
    .en_lm_i  (en_q[LINES-1:0]),
    .irq_o
  );

  // R2
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == STATUS_ADDR |=> en_q == $past(bus_wdata_i[DW-1 -: 2*LINES]));
  // R2
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == STATUS_ADDR) |=> $stable(en_q));
endmodule

// File: tb/sig_irq_regs_bench.sv
module sig_irq_regs_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [15:0] ST_A = 16'h1001;
  localparam logic [15:0] CT_A = 16'h1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, rmt_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, rmt_wdata = '0, rdata;
  logic [1:0]  irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] stat_m = '0;
  logic [1:0] irq_m = '0;

  sig_irq_regs u_sig_irq_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata), .rmt_wr_i(rmt_wr),
    .rmt_wdata_i(rmt_wdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] nxt(logic [7:0] s, logic lw, logic [15:0] a,
                                      logic [7:0] ld, logic rw, logic [7:0] rd);
    logic [7:0] c;
    logic [3:0] en;
    logic [1:0] sg, lm;
    c  = ((lw && a == CT_A) ? ld : 8'h00) | (rw ? rd : 8'h00);
    en = (lw && a == ST_A) ? ld[7:4] : s[7:4];
    sg = (s[3:2] & ~c[3:2]) | c[7:6];
    lm = (s[1:0] & ~c[1:0]) | c[5:4];
    return {en, sg, lm};
  endfunction

  function automatic logic [1:0] irqf(logic [7:0] s);
    return {(s[3] & s[7]) | (s[1] & s[5]), (s[2] & s[6]) | (s[0] & s[4])};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_m <= '0; irq_m <= '0;
    end else begin
      irq_m  <= irqf(stat_m);
      stat_m <= nxt(stat_m, bus_wr, bus_addr, bus_wdata, rmt_wr, rmt_wdata);
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(logic lw, logic [15:0] a, logic [7:0] ld, logic rw, logic [7:0] rd);
    @(negedge clk);
    bus_wr = lw; bus_addr = a; bus_wdata = ld; rmt_wr = rw; rmt_wdata = rd;
    @(posedge clk);
  endtask

  task automatic peek(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b0; rmt_wr = 1'b0; bus_addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    peek(ST_A, d); chk("R1 status", d, 8'h00); chk("R1 irq", {6'b0, irq}, 8'h00);
    peek(CT_A, d); chk("R9 ctrl read", d, 8'h00);
    peek(16'h1002, d); chk("R9 other read", d, 8'h00);

    cyc(1, ST_A, 8'hFF, 0, 8'h00);
    peek(ST_A, d); chk("R2 enables", d, 8'hF0); chk("R3 flags untouched", d & 8'h0F, 8'h00);

    cyc(1, CT_A, 8'h80, 0, 8'h00);
    peek(ST_A, d); chk("R4 set sig1", d, 8'hF8); chk("R8 irq latency", {6'b0, irq}, 8'h00);
    peek(ST_A, d); chk("R8 irq line1", {6'b0, irq}, 8'h02);

    cyc(1, CT_A, 8'h88, 0, 8'h00);
    peek(ST_A, d); chk("R6 set wins", d, 8'hF8);
    cyc(1, CT_A, 8'h00, 0, 8'h00);
    peek(ST_A, d); chk("R5 zero no effect", d, 8'hF8);
    cyc(1, CT_A, 8'h08, 0, 8'h00);
    peek(ST_A, d); chk("R5 clear sig1", d, 8'hF0);

    cyc(1, CT_A, 8'h20, 1, 8'h50);
    peek(ST_A, d); chk("R7 ports ORed", d, 8'hF7);
    cyc(0, ST_A, 8'h00, 1, 8'h04);
    peek(ST_A, d); chk("R7 remote clear", d, 8'hF3);

    cyc(1, 16'h2001, 8'hFF, 0, 8'h00);
    peek(ST_A, d); chk("R10 stray write", d, 8'hF3);
    peek(ST_A, d); chk("R8 both lines", {6'b0, irq}, 8'h03);

    cyc(1, ST_A, 8'h0F, 0, 8'h00);
    peek(ST_A, d); chk("R3 low bits ignored", d, 8'h03);
    peek(ST_A, d); chk("R8 masked", {6'b0, irq}, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, ra;
      logic [7:0]  exp;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? ST_A : (sel == 3) ? 16'($urandom) : CT_A;
      cyc(($urandom_range(0, 3) != 0), a, 8'($urandom),
          ($urandom_range(0, 2) == 0), 8'($urandom));
      sel = $urandom_range(0, 3);
      ra = (sel == 0) ? CT_A : (sel == 1) ? 16'($urandom) : ST_A;
      peek(ra, d);
      exp = (ra == ST_A) ? stat_m : 8'h00;
      chk((ra == ST_A) ? "R2 status" : "R9 readback", d, exp);
      chk("R8 irq", {6'b0, irq}, {6'b0, irq_m});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule